// File: doc/BRIEF.md
# Synchronous Serial Byte Receiver with Request FIFO

This block receives bytes from a host over three wires: a serial clock, a framing strobe and a data line. All three are brought into the system clock domain through two-flop synchronizers. The block watches the synchronized serial clock for rising edges and shifts in one data bit on each. The most significant bit comes first. A rising edge of the framing strobe restarts byte assembly, so the next serial clock rise carries a fresh MSB. After eight bits the byte is written into a 256-entry FIFO, and the bit counter wraps so that the host can stream further bytes without repeating the strobe.

An on-chip consumer drains the FIFO through a valid/ready handshake and can read the current occupancy. The block drives an active-low request output whenever fewer than 64 bytes are stored. A host can therefore send in bursts, refilling the buffer whenever the request is asserted. If a byte completes while the FIFO is full and no read happens in the same cycle, the byte is dropped and a sticky overflow flag is raised.

The host is expected to hold each serial level for at least two system clock periods. It must also leave at least 64 system clock periods between byte starts.

Top module: `ssi_rx_port`

## Requirements
- R1: After reset, `fill_o` is 0, `rd_valid_o` is 0, `ovf_o` is 0, and `req_n_o` is low.
- R2: A data bit is captured on each rising edge of the serial clock. Eight captured bits form one byte, with the first captured bit as bit 7 (MSB) and the last as bit 0. Bytes reach `rd_data_o` in the order they were received.
- R3: A rising edge of the framing strobe, made while the serial clock is low, discards any partially assembled bits. The next serial clock rise becomes bit 7 of a new byte.
- R4: After the eighth bit the byte is stored and assembly restarts at bit 7. Consecutive bytes need no new strobe, and two stores never occur in adjacent system cycles.
- R5: The FIFO holds up to 256 bytes, and `fill_o` gives the stored count. A byte is removed in each cycle where `rd_valid_o` and `rd_ready_i` are both high. `rd_data_o` stays stable while `rd_valid_o` is high and `rd_ready_i` is low.
- R6: `req_n_o` is low while `fill_o` is below 64 and high while `fill_o` is 64 or more.
- R7: A byte that completes while `fill_o` is 256 with no read in that cycle is discarded. In that case `fill_o` stays at 256 and `ovf_o` goes high. `ovf_o` then stays high until reset.
- R8: A byte that completes in the same cycle as a read while the FIFO is full is stored. `fill_o` stays at 256 and `ovf_o` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host (asynchronous) |
| ser_sync_i | input | 1 | Byte framing strobe from host (asynchronous) |
| ser_data_i | input | 1 | Serial data from host (asynchronous) |
| rd_data_o | output | 8 | Oldest stored byte |
| rd_valid_o | output | 1 | FIFO holds at least one byte |
| rd_ready_i | input | 1 | Consumer accepts `rd_data_o` this cycle |
| fill_o | output | 9 | Number of stored bytes |
| ovf_o | output | 1 | Sticky flag: a byte was dropped on a full FIFO |
| req_n_o | output | 1 | Active-low request for more data |

## Verification
A byte store from the deserializer can fall in the same cycle as a consumer read. The critical instance is with the FIFO full, where the outcome decides between accepting the byte and dropping it. The bench fills the FIFO to 256 entries and then sends one more byte. It raises the ready input for exactly the single system cycle in which the eighth bit's synchronized clock edge is recognized, counting both synchronizer stages and the edge detector. The bench passes this case if `fill_o` stays 256, `ovf_o` stays low, and the later drain returns the oldest byte first with the new byte last. A following byte sent with ready low must then be dropped and raise the overflow flag.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
    parameter int unsigned BYTE_W  = 8;
    localparam int unsigned BIT_IDX_W = $clog2(BYTE_W);

    typedef struct packed {
        logic                 sclk_prev;
        logic                 sync_prev;
        logic [BIT_IDX_W-1:0] bit_idx;
        logic [BYTE_W-1:0]    shreg;
    } deser_st_t;
endpackage

// File: rtl/ssi_sync.sv
module ssi_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ssi_deser.sv
module ssi_deser
    import ssi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sync_s,
    input  logic              sdi_s,
    output logic              push_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(BYTE_W - 1);

    deser_st_t st_d, st_q;
    logic      sclk_rise, sync_rise, push_d;

    always_comb begin
        st_d      = st_q;
        push_d    = 1'b0;
        sclk_rise = sclk_s & ~st_q.sclk_prev;
        sync_rise = sync_s & ~st_q.sync_prev;
        st_d.sclk_prev = sclk_s;
        st_d.sync_prev = sync_s;
        if (sync_rise) begin
            st_d.bit_idx = '0;
            st_d.shreg   = '0;
        end
        if (sclk_rise) begin
            st_d.shreg = {st_d.shreg[BYTE_W-2:0], sdi_s};
            if (st_d.bit_idx == LAST_BIT) begin
                push_d       = 1'b1;
                st_d.bit_idx = '0;
            end else begin
                st_d.bit_idx = st_d.bit_idx + BIT_IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign push_o = push_d;
    assign byte_o = st_d.shreg;

    // R4: a byte takes several serial edges, so stores are never adjacent
    a_r4_push_gap: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);
endmodule

// File: rtl/ssi_fifo.sv
module ssi_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [WIDTH-1:0]           din_i,
    input  logic                       rd_ready_i,
    output logic [WIDTH-1:0]           dout_o,
    output logic                       rd_valid_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o,
    output logic                       ovf_o
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } fifo_st_t;

    fifo_st_t         st_d, st_q;
    logic             pop_ok, push_ok;
    logic [WIDTH-1:0] mem [DEPTH];

    always_comb begin
        st_d    = st_q;
        pop_ok  = rd_ready_i && (st_q.cnt != '0);
        push_ok = push_i && ((st_q.cnt != FULL_CNT) || pop_ok);
        if (push_ok) st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + PTR_W'(1);
        if (pop_ok)  st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + PTR_W'(1);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
        if (push_i && !push_ok) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[st_q.wr] <= din_i;
    end

    assign dout_o     = mem[st_q.rd];
    assign rd_valid_o = (st_q.cnt != '0);
    assign cnt_o      = st_q.cnt;
    assign ovf_o      = st_q.ovf;

    // R5: occupancy moves by at most one per cycle
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == $past(st_q.cnt)) || (st_q.cnt == $past(st_q.cnt) + CNT_W'(1))
        || (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));
    // R7: store into a full FIFO without a read is dropped and flagged
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT && push_i && !rd_ready_i) |=> (st_q.cnt == FULL_CNT && st_q.ovf));
    // R7: overflow flag is sticky
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
    // R8: store and read together at full keep the level and raise no overflow
    a_r8_full_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == FULL_CNT && push_i && rd_ready_i) |=> (st_q.cnt == FULL_CNT && st_q.ovf == $past(st_q.ovf)));
endmodule

// File: rtl/ssi_rx_port.sv
module ssi_rx_port #(
    parameter int unsigned DEPTH    = 256,
    parameter int unsigned LOW_MARK = 64,
    parameter int unsigned STAGES   = 2,
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_clk_i,
    input  logic                      ser_sync_i,
    input  logic                      ser_data_i,
    output logic [ssi_pkg::BYTE_W-1:0] rd_data_o,
    output logic                      rd_valid_o,
    input  logic                      rd_ready_i,
    output logic [CNT_W-1:0]          fill_o,
    output logic                      ovf_o,
    output logic                      req_n_o
);
    import ssi_pkg::*;
    localparam logic [CNT_W-1:0] LOW_CNT = CNT_W'(LOW_MARK);

    logic [2:0]        pins_s;
    logic              push;
    logic [BYTE_W-1:0] byte_in;

    ssi_sync #(.WIDTH(3), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_clk_i, ser_sync_i, ser_data_i}),
        .sync_o  (pins_s)
    );

    ssi_deser u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (pins_s[2]),
        .sync_s (pins_s[1]),
        .sdi_s  (pins_s[0]),
        .push_o (push),
        .byte_o (byte_in)
    );

    ssi_fifo #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .din_i      (byte_in),
        .rd_ready_i (rd_ready_i),
        .dout_o     (rd_data_o),
        .rd_valid_o (rd_valid_o),
        .cnt_o      (fill_o),
        .ovf_o      (ovf_o)
    );

    assign req_n_o = (fill_o >= LOW_CNT);

    // R6: request withdraws exactly when the level reaches the mark
    a_r6_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_n_o) |-> (fill_o == LOW_CNT));
    // R5: head byte holds while the consumer stalls
    a_r5_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));
endmodule

// File: tb/ssi_rx_port_tb_top.sv
module ssi_rx_port_tb_top;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0, sync = 1'b0, sdi = 1'b0, ready = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, ovf, req_n;
    logic [8:0] fill;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    ssi_rx_port dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_clk_i  (sclk),
        .ser_sync_i (sync),
        .ser_data_i (sdi),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid),
        .rd_ready_i (ready),
        .fill_o     (fill),
        .ovf_o      (ovf),
        .req_n_o    (req_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b0; sdi = b; tick(HALF);
        sclk = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit keep);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        if (keep) exp_q.push_back(v);
    endtask

    // last bit's rise is seen after two sync stages; pop lands on the same edge as the store
    task automatic send_byte_pop(input logic [7:0] v);
        for (int i = 7; i >= 1; i--) send_bit(v[i]);
        sclk = 1'b0; sdi = v[0]; tick(HALF);
        sclk = 1'b1; tick(2);
        ready = 1'b1; tick(1);
        ready = 1'b0; tick(HALF);
        exp_q.push_back(v);
    endtask

    task automatic strobe();
        sclk = 1'b0; tick(3);
        sync = 1'b1; tick(3);
        sync = 1'b0; tick(3);
    endtask

    task automatic drain();
        ready = 1'b1;
        for (int i = 0; i < 2000 && fill != 0; i++) tick(1);
        ready = 1'b0;
        tick(2);
        chk(exp_q.size() == 0, "R5 drain leaves no expected bytes", exp_q.size(), 0);
        chk(fill == 0, "R5 fill after drain", fill, 0);
    endtask

    // scoreboard monitor (R2 order/bit order)
    always @(negedge clk) begin
        if (rst_n && rd_valid && ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected byte", rd_data, -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R2 byte value/order", rd_data, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(5);
        chk(fill == 0, "R1 fill at reset", fill, 0);
        chk(rd_valid == 0, "R1 valid at reset", rd_valid, 0);
        chk(ovf == 0, "R1 ovf at reset", ovf, 0);
        chk(req_n == 0, "R1 req_n at reset", req_n, 0);
        rst_n = 1'b1;
        tick(3);

        // R2/R4: several bytes streamed after one strobe
        strobe();
        send_byte(8'hA5, 1); send_byte(8'h01, 1); send_byte(8'h80, 1); send_byte(8'h3C, 1);
        chk(fill == 4, "R4 bytes stored without new strobe", fill, 4);
        chk(rd_valid == 1, "R5 valid with data", rd_valid, 1);
        tick(5);
        chk(rd_data == 8'hA5, "R5 head stable while stalled", rd_data, 8'hA5);
        drain();

        // R3: partial bits discarded by strobe
        send_bit(1); send_bit(0); send_bit(1);
        strobe();
        send_byte(8'h5A, 1);
        chk(fill == 1, "R3 one byte after realign", fill, 1);
        send_bit(0); send_bit(1);
        strobe();
        send_byte(8'hC3, 1);
        chk(fill == 2, "R3 second realign", fill, 2);
        drain();

        // R6 then R5 capacity
        for (int i = 0; i < 256; i++) begin
            send_byte(8'(i * 7 + 3), 1);
            if (fill == 63) chk(req_n == 0, "R6 req_n low at 63", req_n, 0);
            if (fill == 64) chk(req_n == 1, "R6 req_n high at 64", req_n, 1);
        end
        chk(fill == 256, "R5 full level", fill, 256);
        chk(ovf == 0, "R5 no overflow at exactly full", ovf, 0);

        // R8: store coincides with a read at full
        send_byte_pop(8'hE7);
        chk(fill == 256, "R8 level kept on swap", fill, 256);
        chk(ovf == 0, "R8 no overflow on swap", ovf, 0);

        // R7: store into full FIFO with no read
        send_byte(8'h99, 0);
        chk(fill == 256, "R7 level after drop", fill, 256);
        chk(ovf == 1, "R7 overflow set", ovf, 1);
        drain();
        chk(ovf == 1, "R7 overflow sticky", ovf, 1);
        chk(req_n == 0, "R6 req_n low when empty", req_n, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule